// File: doc/BRIEF.md
# Streaming 3x3 Difference-of-Gaussian Edge Convolver

This block takes a raster-scanned stream of 8-bit intensity samples, one per clock when `in_valid` is high, and produces a signed 20-bit edge-response value for every accepted sample with no stalls. The kernel sets every one of the eight surrounding taps to -1. Its centre weight depends on the selected kernel mode: 8 for the zero-energy kernel, 9 for the positive-energy kernel and 7 for the negative-energy kernel. In the zero-energy mode a flat region therefore gives zero, and sharp transitions are amplified. The other two modes bias a flat region towards plus or minus the sample value.

Two internal line stores hold the two previous lines, so the 3x3 window is built on the fly. Positions above the top of the frame or left of the start of a line are filled by replicating the nearest sample that exists. The kernel mode is captured once per frame, on the first sample, so a frame never mixes kernels. The output carries a valid flag and start-of-frame and end-of-line markers. These are delayed by the same fixed pipeline latency as the result, so downstream logic sees them aligned with the value.

Top module: `dog_edge_conv3`

## Requirements
- R1: For every clock, `out_valid` equals `in_valid` as sampled exactly 3 clock edges earlier, so each accepted 8-bit sample yields exactly one 20-bit two's-complement result.
- R2: `out_sof` equals (`in_valid` and `in_sof`) and `out_eol` equals (`in_valid` and `in_eol`) as sampled 3 edges earlier.
- R3: Mode code 0, and the spare code 3, select the zero-energy kernel: centre weight +8, the eight other taps -1. A uniform region yields 0.
- R4: Mode code 1 selects the positive-energy kernel with centre weight +9 and the other taps at -1. A uniform region of value p yields +p.
- R5: Mode code 2 selects the negative-energy kernel with centre weight +7 and the other taps at -1. A uniform region of value p yields -p.
- R6: `mode` is sampled only on a sample with `in_valid` and `in_sof` both high. Changes to `mode` elsewhere in the frame do not alter that frame's results.
- R7: The result for the sample at line r, column c covers window rows max(r-2,0), max(r-1,0), r and window columns max(c-2,0), max(c-1,0), c. Each of the nine positions is a separate tap, and the centre tap sits at (max(r-1,0), max(c-1,0)). Lines are counted from the sample flagged `in_sof`, and columns restart after each sample flagged `in_eol`.
- R8: Cycles with `in_valid` low change neither the window, the line stores, nor the captured mode, whatever `in_pixel`, `in_sof`, `in_eol` and `mode` carry. Gaps in the stream therefore leave the results unchanged.
- R9: While `rst` is high, and on the first edge after it rises, `out_valid`, `out_sof` and `out_eol` are low whatever the inputs do. Samples presented during reset produce no result.
- R10: Every valid result lies in the range -2040 to +2295, the extremes reachable with 8-bit samples and the three kernels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on `in_pixel` is part of the image |
| in_pixel | input | 8 | Unsigned intensity sample |
| in_sof | input | 1 | Sample is the first of a frame |
| in_eol | input | 1 | Sample is the last of its line |
| mode | input | 2 | Kernel select: 0 zero-energy, 1 positive-energy, 2 negative-energy, 3 zero-energy |
| out_valid | output | 1 | `out_value` holds a result |
| out_value | output | 20 | Signed two's-complement edge response |
| out_sof | output | 1 | Result belongs to the first sample of a frame |
| out_eol | output | 1 | Result belongs to the last sample of a line |

## Verification
The assertions check on every cycle the fixed three-cycle alignment of valid and the two markers, the quiet outputs after reset, that the captured kernel mode moves only at a frame start, and that every result stays inside its reachable range. The arithmetic cannot be judged one cycle at a time. This covers the centre weight of each mode, the replicated border taps at the top rows and left columns, the immunity to gaps and mid-frame mode changes, and the correct pairing of line-store contents with columns. Only the bench's frames show these, by comparing each result with a behavioural model that stores the whole image and evaluates the clamped window directly.

// File: rtl/dog_pkg.sv
package dog_pkg;

  typedef enum logic [1:0] {
    KM_ZERO  = 2'd0,
    KM_POS   = 2'd1,
    KM_NEG   = 2'd2,
    KM_SPARE = 2'd3
  } kmode_t;

  // Centre weight plus one: result = (w+1)*centre - sum of all nine taps.
  function automatic logic [3:0] centre_plus_one(kmode_t m);
    case (m)
      KM_POS:  return 4'd10;
      KM_NEG:  return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

endpackage

// File: rtl/dog_line_buf.sv
module dog_line_buf #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual-port, read-first, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dog_row_taps.sv
module dog_row_taps #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             first,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] tap0,
  output logic [PIX_W-1:0] tap1,
  output logic [PIX_W-1:0] tap2
);

  logic [PIX_W-1:0] h1, h2;

  // Left-edge replication: on the first column all taps see the new sample.
  assign tap0 = din;
  assign tap1 = first ? din : h1;
  assign tap2 = first ? din : h2;

  always_ff @(posedge clk) begin
    if (rst) begin
      h1 <= '0;
      h2 <= '0;
    end else if (shift) begin
      h1 <= din;
      h2 <= first ? din : h1;
    end
  end

  // R8: the column history moves only on accepted samples
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !shift |=> ($stable(h1) && $stable(h2)));

endmodule

// File: rtl/dog_mac.sv
module dog_mac
  import dog_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OUT_W = 20,
  localparam int SUM_W = PIX_W + 4,
  localparam int NTAP  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  kmode_t           in_mode,
  input  logic [PIX_W-1:0] taps [NTAP],
  input  logic [PIX_W-1:0] centre,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_value,
  output logic             out_sof,
  output logic             out_eol
);

  localparam int PMAX = (2 ** PIX_W) - 1;
  localparam int VMAX = PMAX * 9;
  localparam int VMIN = -(PMAX * 8);

  logic [SUM_W-1:0] tap_sum;
  logic [SUM_W-1:0] a_sum;
  logic [PIX_W-1:0] a_centre;
  logic [3:0]       a_k;
  logic             a_valid, a_sof, a_eol;
  logic [SUM_W-1:0] prod;

  always_comb begin
    tap_sum = '0;
    for (int i = 0; i < NTAP; i++) tap_sum = tap_sum + SUM_W'(taps[i]);
  end

  // Stage A: adder tree and weight selection.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      a_sof   <= 1'b0;
      a_eol   <= 1'b0;
    end else begin
      a_valid <= in_valid;
      a_sof   <= in_sof;
      a_eol   <= in_eol;
    end
    a_sum    <= tap_sum;
    a_centre <= centre;
    a_k      <= centre_plus_one(in_mode);
  end

  assign prod = SUM_W'(a_k) * SUM_W'(a_centre);

  // Stage B: weighted centre minus the tap sum, registered output.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= a_valid;
      out_sof   <= a_sof;
      out_eol   <= a_eol;
      out_value <= OUT_W'(prod) - OUT_W'(a_sum);
    end
  end

  // R10: results stay inside the reachable range
  a_r10_in_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_value) >= VMIN && $signed(out_value) <= VMAX));

endmodule

// File: rtl/dog_edge_conv3.sv
module dog_edge_conv3
  import dog_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int OUT_W    = 20,
  parameter int MAX_LINE = 1024,
  localparam int AW = $clog2(MAX_LINE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [1:0]       mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_value,
  output logic             out_sof,
  output logic             out_eol
);

  localparam int ROWS = 3;
  localparam int NTAP = ROWS * 3;

  // Input-side position tracking.
  logic [AW-1:0] col_q, col_in;
  logic [1:0]    row_q, row_in;
  kmode_t        frame_mode, mode_in;

  assign col_in  = in_sof ? '0 : col_q;
  assign row_in  = in_sof ? 2'd0 : row_q;
  assign mode_in = (in_valid && in_sof) ? kmode_t'(mode) : frame_mode;

  // Stage 1 registers (aligned with the registered line-store reads).
  logic             s1_valid, s1_sof, s1_eol, s1_first;
  logic [PIX_W-1:0] s1_pix;
  logic [AW-1:0]    s1_col;
  logic [1:0]       s1_row;
  kmode_t           s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= '0;
      row_q      <= '0;
      frame_mode <= KM_ZERO;
      s1_valid   <= 1'b0;
      s1_sof     <= 1'b0;
      s1_eol     <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_sof   <= in_valid && in_sof;
      s1_eol   <= in_valid && in_eol;
      if (in_valid) begin
        frame_mode <= mode_in;
        col_q      <= in_eol ? '0 : col_in + 1'b1;
        if (in_eol) row_q <= (row_in == 2'd2) ? 2'd2 : row_in + 2'd1;
        else        row_q <= row_in;
      end
    end
    s1_pix   <= in_pixel;
    s1_col   <= col_in;
    s1_row   <= row_in;
    s1_first <= (col_in == '0);
    s1_mode  <= mode_in;
  end

  // Line stores: A holds the previous line, B the one before it.
  logic [PIX_W-1:0] rd_a, rd_b;

  dog_line_buf #(.DEPTH(MAX_LINE), .WIDTH(PIX_W)) u_line_a (
    .clk   (clk),
    .we    (in_valid),
    .waddr (col_in),
    .wdata (in_pixel),
    .re    (in_valid),
    .raddr (col_in),
    .rdata (rd_a)
  );

  dog_line_buf #(.DEPTH(MAX_LINE), .WIDTH(PIX_W)) u_line_b (
    .clk   (clk),
    .we    (s1_valid),
    .waddr (s1_col),
    .wdata (rd_a),
    .re    (in_valid),
    .raddr (col_in),
    .rdata (rd_b)
  );

  // Top-edge replication: missing upper lines reuse the nearest real one.
  logic [PIX_W-1:0] row_din [ROWS];
  always_comb begin
    row_din[2] = s1_pix;
    row_din[1] = (s1_row != 2'd0) ? rd_a : s1_pix;
    case (s1_row)
      2'd0:    row_din[0] = s1_pix;
      2'd1:    row_din[0] = rd_a;
      default: row_din[0] = rd_b;
    endcase
  end

  logic [PIX_W-1:0] taps [NTAP];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    dog_row_taps #(.PIX_W(PIX_W)) u_taps (
      .clk   (clk),
      .rst   (rst),
      .shift (s1_valid),
      .first (s1_first),
      .din   (row_din[g]),
      .tap0  (taps[g*3]),
      .tap1  (taps[g*3+1]),
      .tap2  (taps[g*3+2])
    );
  end

  dog_mac #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_valid),
    .in_sof    (s1_sof),
    .in_eol    (s1_eol),
    .in_mode   (s1_mode),
    .taps      (taps),
    .centre    (taps[4]),
    .out_valid (out_valid),
    .out_value (out_value),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
  );

  // Edges since reset, used to keep latency checks away from reset history.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: valid follows the input valid by exactly three edges
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R2: markers keep the same alignment
  a_r2_sof_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_sof == $past(in_valid && in_sof, 3)));
  a_r2_eol_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_eol == $past(in_valid && in_eol, 3)));

  // R6: the captured kernel changes only at a frame start
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_sof) |=> $stable(frame_mode));

  // R9: reset leaves the outputs quiet
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sof && !out_eol));

endmodule

// File: tb/dog_edge_conv3_test.sv
module dog_edge_conv3_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_pixel;
  logic        in_sof, in_eol;
  logic [1:0]  mode;
  logic        out_valid, out_sof, out_eol;
  logic [19:0] out_value;

  always #5 clk = ~clk;

  dog_edge_conv3 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pixel(in_pixel),
    .in_sof(in_sof), .in_eol(in_eol), .mode(mode),
    .out_valid(out_valid), .out_value(out_value),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  typedef struct {
    bit    v;
    bit    s;
    bit    e;
    int    val;
    string vtag;
    string tag;
  } rec_t;

  rec_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Behavioural model state
  int img [0:15][0:15];
  int mr = 0, mc = 0, fmode = 0;

  function automatic int mx0(int x);
    return (x < 0) ? 0 : x;
  endfunction

  function automatic int weight(int m);
    if (m == 1) return 9;
    if (m == 2) return 7;
    return 8;
  endfunction

  function automatic int pix(int pat, int r, int c);
    case (pat)
      0: return 100;
      1: return 50;
      2: return (r * 53 + c * 29 + r * c * 7 + 11) % 256;
      3: return ((r + c) % 2 == 1) ? 255 : 0;
      default: return (c * 30 + r * 5) % 256;
    endcase
  endfunction

  function automatic int model_step(int p, bit sof, bit eol, int md);
    int rows[3];
    int cols[3];
    int total, cen, res;
    if (sof) begin
      mr = 0; mc = 0; fmode = md;
    end
    img[mr][mc] = p;
    rows[0] = mx0(mr - 2); rows[1] = mx0(mr - 1); rows[2] = mr;
    cols[0] = mx0(mc - 2); cols[1] = mx0(mc - 1); cols[2] = mc;
    total = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) total += img[rows[i]][cols[j]];
    cen = img[rows[1]][cols[1]];
    res = (weight(fmode) + 1) * cen - total;
    if (eol) begin
      mr++; mc = 0;
    end else mc++;
    return res;
  endfunction

  task automatic compare(rec_t r);
    checks++;
    if (out_valid !== r.v) begin
      errors++;
      $display("FAIL %s out_valid actual %0b expected %0b", r.vtag, out_valid, r.v);
    end
    checks++;
    if (out_sof !== r.s || out_eol !== r.e) begin
      errors++;
      $display("FAIL %s markers actual sof=%0b eol=%0b expected sof=%0b eol=%0b",
               (r.vtag == "R9") ? "R9" : "R2", out_sof, out_eol, r.s, r.e);
    end
    if (r.v && out_valid === 1'b1) begin
      checks++;
      if ($signed(out_value) !== r.val) begin
        errors++;
        $display("FAIL %s out_value actual %0d expected %0d",
                 r.tag, $signed(out_value), r.val);
      end
    end
  endtask

  // One clock: check the result due now, then drive new inputs.
  task automatic cycle(bit r, bit v, int p, bit sof, bit eol, int md, string tag);
    rec_t nr;
    @(negedge clk);
    compare(q.pop_front());
    rst = r; in_valid = v; in_pixel = 8'(p); in_sof = sof; in_eol = eol; mode = 2'(md);
    nr.v = v && !r;
    nr.s = v && !r && sof;
    nr.e = v && !r && eol;
    nr.val = 0;
    nr.vtag = r ? "R9" : "R1";
    nr.tag = tag;
    if (v && !r) nr.val = model_step(p, sof, eol, md);
    q.push_back(nr);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 0, 1'b0, 1'b0, 0, "R1");
  endtask

  task automatic send_frame(int rows, int cols, int md0, int md1, int pat,
                            bit gap, string tag);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        if (gap && ((r * cols + c) % 3 == 2))
          // junk on every other input while idle must be ignored (R8)
          cycle(1'b0, 1'b0, 255 - pix(pat, r, c), 1'b1, 1'b1, 3 - md0, tag);
        cycle(1'b0, 1'b1, pix(pat, r, c), (r == 0 && c == 0), (c == cols - 1),
              (r == 0 && c == 0) ? md0 : md1, tag);
      end
    end
    idle(3);
  endtask

  initial begin
    rec_t blank;
    blank.v = 0; blank.s = 0; blank.e = 0; blank.val = 0;
    blank.vtag = "R9"; blank.tag = "R9";
    for (int i = 0; i < 3; i++) q.push_back(blank);
    rst = 1'b1; in_valid = 1'b0; in_pixel = '0; in_sof = 1'b0; in_eol = 1'b0; mode = '0;
    // R9: samples offered during reset give no result
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 77, 1'b1, 1'b1, 1, "R9");
    idle(4);
    send_frame(5, 8, 0, 0, 0, 1'b0, "R3");   // zero-energy, flat -> 0
    send_frame(5, 9, 3, 3, 2, 1'b0, "R3");   // spare code acts as zero-energy
    send_frame(4, 7, 1, 1, 1, 1'b0, "R4");   // positive-energy, flat -> +p
    send_frame(4, 7, 2, 2, 1, 1'b0, "R5");   // negative-energy, flat -> -p
    send_frame(6, 10, 0, 0, 2, 1'b1, "R8");  // gaps with junk inputs
    send_frame(6, 11, 1, 1, 4, 1'b0, "R7");  // borders on a gradient
    send_frame(6, 12, 0, 0, 2, 1'b0, "R7");  // textured, zero-energy
    send_frame(5, 8, 1, 2, 2, 1'b0, "R6");   // mode moves mid-frame
    send_frame(5, 8, 2, 0, 2, 1'b1, "R6");   // mode moves mid-frame with gaps
    send_frame(5, 8, 1, 1, 3, 1'b0, "R10");  // checkerboard extremes
    send_frame(5, 8, 2, 2, 3, 1'b0, "R10");
    send_frame(4, 6, 0, 0, 3, 1'b0, "R10");
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R1 watchdog expired actual %0d cycles expected below 50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule